// File: doc/BRIEF.md
# Edge-Latched Interrupt Aggregator

This block gathers a small set of asynchronous event lines into one interrupt request. Each line has an enable bit held in a writable enable register. A rising edge on a line whose enable bit is set records a sticky 1 in the matching bit of a readable status register. The request output is raised when the status register as a whole leaves the all-zero state. It is not raised again until every status bit has been cleared.

There is no clear register. Software acknowledges a source by writing its enable bit to 0, which empties the status bit at that same clock edge. Software then writes the bit back to 1 to arm the source again. Each event line passes through a two-stage synchronizer before edge detection, so the lines may come from any clock domain. A parameter selects the request style. In pulse style the request is one clock cycle wide on the zero-to-non-zero step. In level style the request is high for as long as any status bit is set.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is asserted, the enable register and the status register are all zero and irq_o is 0.
- R2: A 0-to-1 change on src_i[k] while enable bit k is 1 sets sts_o[k]. The bit position in sts_o equals the source index. The bit first reads 1 after the third rising clock edge that follows the input change.
- R3: While enable bit k is 0, sts_o[k] reads 0, and edges on src_i[k] leave the status unchanged.
- R4: A write with en_wr_i=1 and en_wdata_i[k]=0 makes sts_o[k] read 0 after that clock edge. This holds even when an edge on source k is detected at that same edge.
- R5: A write that sets enable bit k at the same edge where an edge on source k is detected latches sts_o[k] to 1.
- R6: In pulse style, irq_o is 1 for exactly one cycle: the first cycle in which sts_o is non-zero after having been zero.
- R7: In pulse style, irq_o stays 0 while the status only changes among non-zero values. This includes one bit being cleared while another is set at the same edge.
- R8: In level style, irq_o equals the OR of all bits of sts_o in every cycle.
- R9: A set status bit stays 1, whatever its source line does afterward, until its enable bit is written to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Event lines, asynchronous to clk |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NUM_SRC | New enable register value |
| sts_o | output | NUM_SRC | Status register read value, bit k for source k |
| irq_o | output | 1 | Interrupt request (pulse or level, per IRQ_MODE) |

## Verification
Two functions can fall on the same clock edge: the detection of a synchronized rising edge and an enable write that touches the same or a different source. The bench counts the synchronizer delay. It places the write strobe on exactly the edge where the detected edge is presented. This yields three cases: a disable that must win over the edge on the same bit, an enable that must let the edge through, and a disable of one bit while another bit sets. For each case, the bench judges the status value read one cycle later. It also counts request pulses across the step to show that a status which never passes through zero raises no new request.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

   typedef enum logic {
      IRQ_PULSE = 1'b0,
      IRQ_LEVEL = 1'b1
   } irq_mode_e;

   localparam int unsigned MAX_SRC = 32;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= '0;
         end else if (s == 0) begin
            chain_q[s] <= d_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);

   logic [WIDTH-1:0] lvl_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d_q <= '0;
      end else begin
         lvl_d_q <= lvl_i;
      end
   end

   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      assign rise_o[k] = lvl_i[k] & ~lvl_d_q[k];
   end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [WIDTH-1:0] rise_i,
   output logic [WIDTH-1:0] en_o,
   output logic [WIDTH-1:0] sts_o,
   output logic [WIDTH-1:0] sts_nxt_o
);

   logic [WIDTH-1:0] en_q;
   logic [WIDTH-1:0] en_nxt;
   logic [WIDTH-1:0] sts_q;

   // The enable value in force after this edge gates both the set and the hold.
   always_comb begin
      en_nxt = wr_i ? wdata_i : en_q;
   end

   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      assign sts_nxt_o[k] = en_nxt[k] & (sts_q[k] | rise_i[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sts_q <= '0;
      end else begin
         en_q  <= en_nxt;
         sts_q <= sts_nxt_o;
      end
   end

   assign en_o  = en_q;
   assign sts_o = sts_q;

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
   import irq_latch_pkg::*;
#(
   parameter int unsigned WIDTH    = 6,
   parameter irq_mode_e   IRQ_MODE = IRQ_PULSE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sts_nxt_i,
   output logic             irq_o
);

   logic any_nxt;
   logic irq_q;

   assign any_nxt = |sts_nxt_i;

   if (IRQ_MODE == IRQ_LEVEL) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= any_nxt;
         end
      end
   end else begin : g_pulse
      logic any_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            any_q <= 1'b0;
            irq_q <= 1'b0;
         end else begin
            any_q <= any_nxt;
            irq_q <= any_nxt & ~any_q;
         end
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
   import irq_latch_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter irq_mode_e   IRQ_MODE    = IRQ_PULSE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               en_wr_i,
   input  logic [NUM_SRC-1:0] en_wdata_i,
   output logic [NUM_SRC-1:0] sts_o,
   output logic               irq_o
);

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_width
      $error("irq_latch_ctrl: NUM_SRC out of range");
   end

   logic [NUM_SRC-1:0] src_sync;
   logic [NUM_SRC-1:0] src_rise;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] sts_nxt;

   irq_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_sync)
   );

   irq_rise_det #(
      .WIDTH (NUM_SRC)
   ) rise_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (src_sync),
      .rise_o (src_rise)
   );

   irq_status_reg #(
      .WIDTH (NUM_SRC)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (en_wr_i),
      .wdata_i   (en_wdata_i),
      .rise_i    (src_rise),
      .en_o      (en_q),
      .sts_o     (sts_o),
      .sts_nxt_o (sts_nxt)
   );

   irq_req_gen #(
      .WIDTH    (NUM_SRC),
      .IRQ_MODE (IRQ_MODE)
   ) req_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sts_nxt_i (sts_nxt),
      .irq_o     (irq_o)
   );

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
   import irq_latch_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 6,
   parameter irq_mode_e   IRQ_MODE = IRQ_PULSE
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_wr_i,
   input logic [NUM_SRC-1:0] en_wdata_i,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] sts_o,
   input logic               irq_o
);

   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_clear: assert (sts_o == '0 && en_q == '0 && irq_o == 1'b0)
            else $error("R1 state not cleared in reset");
      end
   end

   a_r3_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((sts_o & ~en_q) == '0));

   a_r4_disable_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr_i |=> ((sts_o & ~$past(en_wdata_i)) == '0));

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

   if (IRQ_MODE == IRQ_LEVEL) begin : g_level_chk
      a_r8_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |-> (irq_o == (sts_o != '0)));
   end else begin : g_pulse_chk
      a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |=> !irq_o);
      a_r6_on_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (sts_o != '0 && $past(sts_o) == '0));
      a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(sts_o) != '0) |-> !irq_o);
   end

endmodule

bind irq_latch_ctrl irq_latch_chk #(
   .NUM_SRC  (NUM_SRC),
   .IRQ_MODE (IRQ_MODE)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_wr_i    (en_wr_i),
   .en_wdata_i (en_wdata_i),
   .en_q       (en_q),
   .sts_o      (sts_o),
   .irq_o      (irq_o)
);

// File: tb/irq_latch_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_latch_ctrl_tb_top;
   import irq_latch_pkg::*;

   localparam int N = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src = '0;
   logic         wr = 1'b0;
   logic [N-1:0] wdata = '0;
   logic [N-1:0] sts_p, sts_l;
   logic         irq_p, irq_l;

   int checks = 0;
   int fails  = 0;
   int pulses = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   irq_latch_ctrl #(.NUM_SRC(N), .IRQ_MODE(IRQ_PULSE)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .en_wr_i(wr),
      .en_wdata_i(wdata), .sts_o(sts_p), .irq_o(irq_p));

   irq_latch_ctrl #(.NUM_SRC(N), .IRQ_MODE(IRQ_LEVEL)) dut_lvl_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .en_wr_i(wr),
      .en_wdata_i(wdata), .sts_o(sts_l), .irq_o(irq_l));

   always @(negedge clk) if (rst_n && irq_p) pulses++;

   // {enable, source pattern, expected status, expected pulse count}
   typedef struct packed {
      logic [5:0] en;
      logic [5:0] pat;
      logic [5:0] exp_sts;
      logic [1:0] exp_pulses;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{6'h3F, 6'h01, 6'h01, 2'd1},
      '{6'h3F, 6'h04, 6'h05, 2'd0},
      '{6'h3E, 6'h00, 6'h04, 2'd0},
      '{6'h00, 6'h00, 6'h00, 2'd0},
      '{6'h0F, 6'h30, 6'h00, 2'd0},
      '{6'h0F, 6'h0A, 6'h0A, 2'd1},
      '{6'h3F, 6'h20, 6'h2A, 2'd0},
      '{6'h00, 6'h3F, 6'h00, 2'd0},
      '{6'h3F, 6'h3F, 6'h3F, 2'd1}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_en(logic [N-1:0] v);
      @(negedge clk);
      wr = 1'b1; wdata = v;
      @(negedge clk);
      wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int p0;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 status", sts_p, 0);
      check("R1 irq", {irq_p, irq_l}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", sts_p, 0);

      // table walk: R2 R3 R4 R6 R7 R8 R9
      foreach (VECS[i]) begin
         p0 = pulses;
         @(negedge clk);
         wr = 1'b1; wdata = VECS[i].en;
         @(negedge clk);
         wr = 1'b0; src = VECS[i].pat;
         repeat (4) @(negedge clk);
         src = '0;
         repeat (3) @(negedge clk);
         check($sformatf("R2/R3/R9 vec %0d status", i), sts_p, VECS[i].exp_sts);
         check($sformatf("R6/R7 vec %0d pulses", i), pulses - p0, VECS[i].exp_pulses);
         check($sformatf("R8 vec %0d level", i), irq_l, VECS[i].exp_sts != 0);
      end

      // R2: latency through synchronizer and edge detect
      write_en(6'h00);
      write_en(6'h01);
      src = 6'h01;                       // N0
      @(negedge clk); @(negedge clk);    // N2
      check("R2 not yet at edge 2", sts_p, 0);
      @(negedge clk);                    // N3
      check("R2 set at edge 3", sts_p, 6'h01);
      check("R6 pulse high", irq_p, 1);
      @(negedge clk);
      check("R6 pulse gone", irq_p, 0);
      src = '0;
      repeat (3) @(negedge clk);

      // R4: disable coincident with detected edge on same bit, clear wins
      write_en(6'h00);
      write_en(6'h01);
      repeat (3) @(negedge clk);
      p0 = pulses;
      src = 6'h01;
      @(negedge clk); @(negedge clk);
      wr = 1'b1; wdata = 6'h00;
      @(negedge clk);
      wr = 1'b0;
      check("R4 clear wins over edge", sts_p, 0);
      repeat (3) @(negedge clk);
      check("R4 stays clear", sts_p, 0);
      check("R4 no pulse", pulses - p0, 0);
      src = '0;
      repeat (3) @(negedge clk);

      // R5: enable coincident with detected edge latches
      p0 = pulses;
      src = 6'h02;
      @(negedge clk); @(negedge clk);
      wr = 1'b1; wdata = 6'h02;
      @(negedge clk);
      wr = 1'b0;
      check("R5 enable with edge latches", sts_p, 6'h02);
      src = '0;
      repeat (3) @(negedge clk);
      check("R5 one pulse", pulses - p0, 1);

      // R7: clear bit1 while bit0 sets at same edge, no new request
      write_en(6'h03);
      repeat (2) @(negedge clk);
      p0 = pulses;
      src = 6'h01;
      @(negedge clk); @(negedge clk);
      wr = 1'b1; wdata = 6'h01;
      @(negedge clk);
      wr = 1'b0;
      check("R7 swap status", sts_p, 6'h01);
      src = '0;
      repeat (3) @(negedge clk);
      check("R7 no pulse on swap", pulses - p0, 0);
      check("R8 level held", irq_l, 1);
      write_en(6'h00);
      check("R8 level dropped", irq_l, 0);
      check("R3 cleared by disable", sts_p, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule